// File: doc/BRIEF.md
# Processor interrupt pin front end

This block conditions the raw interrupt and control pins of a processor core before they reach the core's pending-interrupt logic. Seven pins arrive asynchronously: external interrupt, system-management interrupt, machine check, checkstop, hard reset, soft reset and time-base enable. Each pin is synchronised to the core clock and compared against a stored copy of its last value. Only a difference between the two counts as an event; repeated samples at one level do nothing. The events are then turned into a pending-source vector, a summary request line, a reset request, a halt line and a run enable for the time base.

Every pin has its own sensitivity rule. External, system-management and soft-reset requests are active-high levels whose pending bits track the pin. Machine check reacts only to a falling edge and stays pending until the core acknowledges it by source index. Checkstop and hard reset are active low. A checkstop halts the core until the block is reset, and hard reset raises a reset request for as long as the pin is low. Time-base enable lets the time base count while it is high.

Top module: `cpu_pin_frontend`

## Requirements
- R1: While rst_ni is low and on its release, pend_o is 0, irq_o, halt_o, reset_req_o and tb_run_o are 0. The stored pin state resets to inactive levels, so pins held at inactive levels at release create no events.
- R2: Each pin passes through two synchroniser flops and then a stored-state flop. A pin change driven before rising edge n first shows on the outputs after rising edge n+2.
- R3: pend_o[0] (external interrupt) follows the synchronised level of ext_irq_i, active high.
- R4: pend_o[1] (system-management interrupt) follows the synchronised level of smi_i, active high.
- R5: pend_o[2] (machine check) is set by a 1-to-0 transition of mchk_i. A rising edge, or mchk_i held low, does not set it. Once set, it stays set after the pin returns high.
- R6: On a rising edge with ack_valid_i high and ack_idx_i equal to 2, pend_o[2] clears, unless a machine-check falling edge sets it on that same edge, in which case it stays 1. An acknowledge with any other index leaves pend_o unchanged.
- R7: A 1-to-0 transition of ckstop_ni sets halt_o. halt_o stays 1 after the pin returns high, until rst_ni is asserted.
- R8: reset_req_o is 1 exactly while the synchronised hreset_ni is low.
- R9: pend_o[3] (soft reset) follows the synchronised level of sreset_i, active high.
- R10: tb_run_o is 1 while the synchronised tben_i is high and 0 while it is low.
- R11: irq_o is 1 whenever any bit of pend_o is set, and 0 only when pend_o is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_irq_i | input | 1 | External interrupt, level, active high |
| smi_i | input | 1 | System-management interrupt, level, active high |
| mchk_i | input | 1 | Machine check, falling-edge sensitive |
| ckstop_ni | input | 1 | Checkstop, active low |
| hreset_ni | input | 1 | Hard reset, active low |
| sreset_i | input | 1 | Soft reset interrupt, level, active high |
| tben_i | input | 1 | Time-base enable, active high |
| ack_valid_i | input | 1 | One-cycle acknowledge strobe |
| ack_idx_i | input | 2 | Source index being acknowledged (2 = machine check) |
| pend_o | output | 4 | Pending sources: bit0 external, bit1 system-management, bit2 machine check, bit3 soft reset |
| irq_o | output | 1 | Summary request, OR of pending sources |
| reset_req_o | output | 1 | Core reset request |
| halt_o | output | 1 | Core halted by checkstop |
| tb_run_o | output | 1 | Time-base run enable |

## Verification
The properties assume that rst_ni is the only way to leave the halted state, and that ack_idx_i carries meaning only in cycles where ack_valid_i is high. The latency properties also assume that every pin stays asynchronous to nothing faster than the core clock, so that each level is seen by the first synchroniser flop. The stimulus changes pins and the acknowledge only on falling clock edges and leaves each value in place for at least one full cycle. It also keeps reset asserted over several rising edges, so every sampled value is a clean, stable level.

// File: rtl/pin_fe_pkg.sv
package pin_fe_pkg;
  localparam int unsigned NUM_PINS = 7;
  localparam int unsigned NUM_SRC  = 4;
  localparam int unsigned SRC_W    = $clog2(NUM_SRC);

  typedef enum int unsigned {
    PIN_EXT    = 0,
    PIN_SMI    = 1,
    PIN_MCHK   = 2,
    PIN_CKSTOP = 3,
    PIN_HRESET = 4,
    PIN_SRESET = 5,
    PIN_TBEN   = 6
  } pin_e;

  // inactive level of each pin, bit index = pin_e
  localparam logic [NUM_PINS-1:0] PIN_IDLE = 7'b0011100;

  localparam logic [SRC_W-1:0] SRC_MCHK_IDX = 2'd2;
  // sources that latch on a falling edge instead of following the pin
  localparam logic [NUM_SRC-1:0] SRC_STICKY = 4'b0100;

  function automatic int unsigned src_pin(int unsigned s);
    case (s)
      0:       return PIN_EXT;
      1:       return PIN_SMI;
      2:       return PIN_MCHK;
      default: return PIN_SRESET;
    endcase
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pin_tracker.sv
module pin_tracker #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] smp_i,
  output logic [W-1:0] chg_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= RST_VAL;
    else         last_q <= smp_i;
  end

  assign chg_o  = smp_i ^ last_q;
  assign fall_o = chg_o & ~smp_i;
endmodule

// File: rtl/pend_ctrl.sv
module pend_ctrl
  import pin_fe_pkg::*;
#(
  parameter int unsigned N_PIN = NUM_PINS,
  parameter int unsigned N_SRC = NUM_SRC,
  localparam int unsigned IW   = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_PIN-1:0] smp_i,
  input  logic [N_PIN-1:0] chg_i,
  input  logic [N_PIN-1:0] fall_i,
  input  logic             ack_valid_i,
  input  logic [IW-1:0]    ack_idx_i,
  output logic [N_SRC-1:0] pend_o
);
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    localparam int unsigned P = src_pin(s);
    if (SRC_STICKY[s]) begin : g_edge
      logic clr;
      assign clr = ack_valid_i && (ack_idx_i == IW'(s));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        pend_o[s] <= 1'b0;
        else if (fall_i[P]) pend_o[s] <= 1'b1;
        else if (clr)       pend_o[s] <= 1'b0;
      end
    end else begin : g_lvl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       pend_o[s] <= 1'b0;
        else if (chg_i[P]) pend_o[s] <= smp_i[P];
      end
    end
  end
endmodule

// File: rtl/cpu_pin_frontend.sv
module cpu_pin_frontend
  import pin_fe_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_irq_i,
  input  logic               smi_i,
  input  logic               mchk_i,
  input  logic               ckstop_ni,
  input  logic               hreset_ni,
  input  logic               sreset_i,
  input  logic               tben_i,
  input  logic               ack_valid_i,
  input  logic [SRC_W-1:0]   ack_idx_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               irq_o,
  output logic               reset_req_o,
  output logic               halt_o,
  output logic               tb_run_o
);
  logic [NUM_PINS-1:0] raw, smp, chg, fall;

  assign raw = {tben_i, sreset_i, hreset_ni, ckstop_ni, mchk_i, smi_i, ext_irq_i};

  pin_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (smp)
  );

  pin_tracker #(.W(NUM_PINS), .RST_VAL(PIN_IDLE)) u_trk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .smp_i (smp),
    .chg_o (chg),
    .fall_o(fall)
  );

  pend_ctrl #(.N_PIN(NUM_PINS), .N_SRC(NUM_SRC)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smp_i      (smp),
    .chg_i      (chg),
    .fall_i     (fall),
    .ack_valid_i(ack_valid_i),
    .ack_idx_i  (ack_idx_i),
    .pend_o     (pend_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_o      <= 1'b0;
      reset_req_o <= 1'b0;
      tb_run_o    <= 1'b0;
    end else begin
      if (fall[PIN_CKSTOP]) halt_o      <= 1'b1;  // only rst_ni restarts
      if (chg[PIN_HRESET])  reset_req_o <= ~smp[PIN_HRESET];
      if (chg[PIN_TBEN])    tb_run_o    <= smp[PIN_TBEN];
    end
  end

  assign irq_o = |pend_o;
endmodule

// File: rtl/cpu_pin_frontend_chk.sv
module cpu_pin_frontend_chk
  import pin_fe_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ext_irq_i,
  input logic               smi_i,
  input logic               mchk_i,
  input logic               ckstop_ni,
  input logic               hreset_ni,
  input logic               sreset_i,
  input logic               tben_i,
  input logic               ack_valid_i,
  input logic [SRC_W-1:0]   ack_idx_i,
  input logic [NUM_SRC-1:0] pend_o,
  input logic               irq_o,
  input logic               reset_req_o,
  input logic               halt_o,
  input logic               tb_run_o
);
  a_r7_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);

  a_r5_mchk_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o[2] && !(ack_valid_i && ack_idx_i == SRC_MCHK_IDX)) |=> pend_o[2]);

  a_r6_mchk_clear_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_o[2]) |-> $past(ack_valid_i && ack_idx_i == SRC_MCHK_IDX));

  a_r11_irq_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> (pend_o == '0));

  a_r2_ext_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o[0]) |-> $past(ext_irq_i, 3));

  a_r8_hreset_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reset_req_o) |-> !$past(hreset_ni, 3));

  a_r10_tb_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tb_run_o) |-> $past(tben_i, 3));
endmodule

bind cpu_pin_frontend cpu_pin_frontend_chk u_chk (.*);

// File: tb/cpu_pin_frontend_test.sv
module cpu_pin_frontend_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext = 0, smi = 0, mchk = 1, ckstop_n = 1, hreset_n = 1, sreset = 0, tben = 0;
  logic ack_v = 0;
  logic [1:0] ack_idx = 0;
  logic [3:0] pend;
  logic irq, rreq, halt, tbrun;

  always #2 clk = ~clk;  // 250 MHz

  cpu_pin_frontend uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_irq_i(ext), .smi_i(smi), .mchk_i(mchk),
    .ckstop_ni(ckstop_n), .hreset_ni(hreset_n), .sreset_i(sreset), .tben_i(tben),
    .ack_valid_i(ack_v), .ack_idx_i(ack_idx), .pend_o(pend), .irq_o(irq),
    .reset_req_o(rreq), .halt_o(halt), .tb_run_o(tbrun)
  );

  localparam logic [6:0] IDLE = 7'b0011100;
  int n_vec = 0, n_bad = 0, cyc = 0;
  bit chk_en = 0, done = 0;

  // reference model: pin history of the last three sampled edges
  logic [6:0] hist[$];
  logic [3:0] m_pend;
  logic m_halt, m_rreq, m_tb;
  logic [6:0] pins;
  assign pins = {tben, sreset, hreset_n, ckstop_n, mchk, smi, ext};

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{IDLE, IDLE, IDLE};
      m_pend = 0; m_halt = 0; m_rreq = 0; m_tb = 0;
    end else begin
      logic [6:0] cur, old;
      hist.push_back(pins);
      cur = hist[1];
      old = hist[0];
      if (cur[0] != old[0]) m_pend[0] = cur[0];
      if (cur[1] != old[1]) m_pend[1] = cur[1];
      if (old[2] && !cur[2]) m_pend[2] = 1;
      else if (ack_v && ack_idx == 2) m_pend[2] = 0;
      if (cur[5] != old[5]) m_pend[3] = cur[5];
      if (old[3] && !cur[3]) m_halt = 1;
      if (cur[4] != old[4]) m_rreq = !cur[4];
      if (cur[6] != old[6]) m_tb = cur[6];
      void'(hist.pop_front());
    end
  end

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (chk_en) begin
      chk("R3 ext pend", {3'b0, pend[0]}, {3'b0, m_pend[0]});
      chk("R4 smi pend", {3'b0, pend[1]}, {3'b0, m_pend[1]});
      chk("R5 mchk pend", {3'b0, pend[2]}, {3'b0, m_pend[2]});
      chk("R9 sreset pend", {3'b0, pend[3]}, {3'b0, m_pend[3]});
      chk("R11 irq", {3'b0, irq}, {3'b0, |m_pend});
      chk("R7 halt", {3'b0, halt}, {3'b0, m_halt});
      chk("R8 reset_req", {3'b0, rreq}, {3'b0, m_rreq});
      chk("R10 tb_run", {3'b0, tbrun}, {3'b0, m_tb});
    end
    if (cyc > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog R1 actual=%0d expected=<100000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    chk_en = 0;
    @(negedge clk);
    rst_n = 0;
    tick(3);
    rst_n = 1;
    tick(1);
    chk("R1 reset pend", pend, 4'h0);
    chk("R1 reset ctl", {irq, halt, rreq, tbrun}, 4'h0);
    chk_en = 1;
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    chk("R1 initial pend", pend, 4'h0);
    chk("R1 initial ctl", {irq, halt, rreq, tbrun}, 4'h0);
    chk_en = 1;
    tick(5);
    chk("R1 idle pins no event", {irq, halt, rreq, tbrun}, 4'h0);

    // R2 latency on external interrupt
    ext = 1;
    tick(2);
    chk("R2 ext before third edge", {3'b0, pend[0]}, 4'h0);
    tick(1);
    chk("R2 ext on third edge", {3'b0, pend[0]}, 4'h1);
    tick(4); ext = 0; tick(5);

    smi = 1; tick(4); sreset = 1; tick(4); smi = 0; tick(4); sreset = 0; tick(5);
    ext = 1; smi = 1; sreset = 1; tick(4); ext = 0; smi = 0; sreset = 0; tick(5);

    // R5 machine check: falling edge sets, return high keeps it
    mchk = 0; tick(6);
    chk("R5 mchk set on fall", {3'b0, pend[2]}, 4'h1);
    mchk = 1; tick(6);
    chk("R5 mchk sticky after rise", {3'b0, pend[2]}, 4'h1);
    // R6 wrong index ignored
    ack_v = 1; ack_idx = 0; tick(1); ack_v = 0; tick(1);
    chk("R6 other index ignored", pend, 4'h4);
    ack_v = 1; ack_idx = 2; tick(1); ack_v = 0; tick(1);
    chk("R6 ack clears mchk", pend, 4'h0);
    // R6 set wins over same-edge ack
    mchk = 0; tick(2);
    ack_v = 1; ack_idx = 2; tick(1); ack_v = 0;
    chk("R6 set beats ack", {3'b0, pend[2]}, 4'h1);
    tick(3); mchk = 1; tick(4);
    ack_v = 1; ack_idx = 2; tick(1); ack_v = 0; tick(2);
    // rising edge alone never sets
    mchk = 1; tick(5);
    chk("R5 no set while high", {3'b0, pend[2]}, 4'h0);
    // one-cycle glitch low still seen
    mchk = 0; tick(1); mchk = 1; tick(5);
    chk("R5 glitch fall sets", {3'b0, pend[2]}, 4'h1);
    ack_v = 1; ack_idx = 2; tick(1); ack_v = 0; tick(2);

    hreset_n = 0; tick(3);
    chk("R8 reset_req while low", {3'b0, rreq}, 4'h1);
    tick(2); hreset_n = 1; tick(4);
    chk("R8 reset_req released", {3'b0, rreq}, 4'h0);

    tben = 1; tick(3);
    chk("R10 tb runs", {3'b0, tbrun}, 4'h1);
    tick(5); tben = 0; tick(5);

    ckstop_n = 0; tick(4); ckstop_n = 1; tick(6);
    chk("R7 halt held after pin high", {3'b0, halt}, 4'h1);
    do_reset();
    chk("R7 halt cleared by reset", {3'b0, halt}, 4'h0);

    // mixed stretch
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      ext = r[0]; smi = r[1]; sreset = r[2]; tben = r[3];
      mchk = r[4] | r[5];
      hreset_n = r[6] | r[7];
      ckstop_n = (i < 300) ? 1'b1 : (r[8] | r[9] | r[10]);
      ack_v = r[11]; ack_idx = r[13:12];
      tick(1 + int'(r[15:14]));
    end
    ack_v = 0;
    tick(5);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule